// File: doc/BRIEF.md
# Interrupt Distributor Register Front End

This block is the memory-mapped register file of a shared interrupt distributor for a multi-core system. A single-cycle register bus reaches it: each request carries a valid strobe, a write enable, a 12-bit word address and 32 bits of write data. For every read, the block returns registered data one cycle later. Internally it keeps four kinds of state:

- a global group-1 delivery enable;
- an enable bitmap with separate set and clear windows;
- a pending bitmap with separate set and clear windows;
- byte-wide priority fields and two-bit configuration fields for each shared interrupt.

Interrupt IDs 0 to 31 belong to the individual cores and are not served here. Every access that lands on them through this window reads zero and changes nothing. The enable vector, the pending vector and the global enable go straight to the delivery logic.

Several register ranges have no state behind them. The group range reads as all ones. The identification range reads as fixed constants. All other addresses, including the active-state, legacy-target, group-modifier, access-control, software-interrupt and message ranges, read zero and ignore writes.

`NUM_IRQS` sets the number of interrupt IDs. It must be a multiple of 32 between 64 and 1024.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset the group-1 enable, every enable bit, every pending bit, every priority byte and every configuration field are zero, and `rsp_valid` is low.
- R2: A read request makes `rsp_valid` high with the read data on the next cycle only. A write request, or no request, leaves `rsp_valid` low on the next cycle.
- R3: Word 0x000 is the control register. Bit 1 is the stored group-1 enable: it is writable and drives `grp1_en`. Bit 0 (group-0 enable) always reads 0, and setting it has no effect. Bits 4 and 6 always read 1. All other bits read 0.
- R4: Word 0x001 is read-only. Bits 4:0 hold min(NUM_IRQS,1024)/32 − 1. Bits 23:19 hold 9, which is the 10-bit ID width minus one. All other bits read 0, and writes are ignored.
- R5: Writing to word 0x040+w sets the enable bit of IRQ 32w+b for each data bit b that is one. Writing to word 0x060+w clears that bit. Zero data bits leave the matching bits unchanged. Reading either word returns the current enable bits, and `irq_enable` reflects them.
- R6: The pending bitmap behaves the same way: set at word 0x080+w, clear at word 0x0A0+w. `irq_pending` reflects the bits.
- R7: In all four bitmap ranges, word w=0 (IRQs 0–31) and words with 32w ≥ NUM_IRQS read zero and ignore writes. Bits 31:0 of `irq_enable` and `irq_pending` are always zero.
- R8: Word 0x100+p holds the priority of IRQ 4p+k in bits 8k+7:8k. Words with 4p ≥ 32 and 4p < NUM_IRQS store what is written and read it back. Words with p < 8 read zero and ignore writes.
- R9: Word 0x300+c holds the two-bit configuration of IRQ 16c+j in bits 2j+1:2j. Words with c ≥ 2 and 16c < NUM_IRQS are stored and read back. Words with c < 2 read zero and ignore writes.
- R10: Words 0x020 to 0x03F read 0xFFFFFFFF, and writes to them are ignored.
- R11: Word 0xFFA reads 0x0000003B. The other identification words, 0xFF4 to 0xFFF, read zero.
- R12: Every other address reads zero. A write to such an address changes neither `grp1_en`, `irq_enable` nor `irq_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Registered read data |
| grp1_en | output | 1 | Global group-1 delivery enable |
| irq_enable | output | NUM_IRQS | Per-interrupt enable vector |
| irq_pending | output | NUM_IRQS | Per-interrupt pending vector |

## Verification
The directed cases come first:

- Set and clear writes with mixed ones and zeros in the data check that zero bits leave state alone. A pure-store design would fail these.
- Writes aimed at word 0 and at the word just past the implemented count check that the private and unimplemented ranges stay inert. Readbacks show this, and so does the output vector.
- Writing all ones to the control and type words shows which bits are fixed and which are stored.

A seeded random stream then mixes reads and writes across every range with arbitrary data, including fully random addresses. This exposes any decode overlap between neighbouring ranges, because a stray write shows up in a later readback of an unrelated word.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int ID_BITS   = 10;
    localparam int MAX_IRQS  = 1024;

    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] A_TYPE   = 12'h001;
    localparam logic [ADDR_W-1:0] A_GROUP  = 12'h020;
    localparam logic [ADDR_W-1:0] A_SET_EN = 12'h040;
    localparam logic [ADDR_W-1:0] A_CLR_EN = 12'h060;
    localparam logic [ADDR_W-1:0] A_SET_PD = 12'h080;
    localparam logic [ADDR_W-1:0] A_CLR_PD = 12'h0A0;
    localparam logic [ADDR_W-1:0] A_PRIO   = 12'h100;
    localparam logic [ADDR_W-1:0] A_CFG    = 12'h300;
    localparam logic [ADDR_W-1:0] A_IDENT2 = 12'hFFA;

    localparam logic [DATA_W-1:0] IDENT2_VALUE = 32'h0000_003B;

    typedef enum logic [3:0] {
        RG_ZERO,
        RG_CTRL,
        RG_TYPE,
        RG_GROUP,
        RG_SET_EN,
        RG_CLR_EN,
        RG_SET_PD,
        RG_CLR_PD,
        RG_PRIO,
        RG_CFG,
        RG_IDENT2
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [7:0] index;
    } decode_t;

    typedef struct packed {
        logic [24:0] rsvd_hi;
        logic        sec_off;
        logic        rsvd_5;
        logic        route_on;
        logic [1:0]  rsvd_3_2;
        logic        grp1;
        logic        grp0;
    } ctrl_word_t;

    function automatic logic [DATA_W-1:0] type_word(input int n_irqs);
        int capped;
        capped = (n_irqs > MAX_IRQS) ? MAX_IRQS : n_irqs;
        return DATA_W'((capped / 32) - 1) | DATA_W'((ID_BITS - 1) << 19);
    endfunction

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.region = RG_ZERO;
        d.index  = a[7:0];
        if (a == A_CTRL)                      d.region = RG_CTRL;
        else if (a == A_TYPE)                 d.region = RG_TYPE;
        else if (a[11:5] == A_GROUP[11:5])    d.region = RG_GROUP;
        else if (a[11:5] == A_SET_EN[11:5])   d.region = RG_SET_EN;
        else if (a[11:5] == A_CLR_EN[11:5])   d.region = RG_CLR_EN;
        else if (a[11:5] == A_SET_PD[11:5])   d.region = RG_SET_PD;
        else if (a[11:5] == A_CLR_PD[11:5])   d.region = RG_CLR_PD;
        else if (a[11:8] == A_PRIO[11:8])     d.region = RG_PRIO;
        else if (a[11:6] == A_CFG[11:6])      d.region = RG_CFG;
        else if (a == A_IDENT2)               d.region = RG_IDENT2;
        return d;
    endfunction

endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
    import irqd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    always_comb dec = decode_addr(addr);
endmodule

// File: rtl/irqd_setclr_map.sv
module irqd_setclr_map #(
    parameter int N_IRQS     = 96,
    parameter int FIRST_WORD = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [4:0]        word_idx,
    input  logic [31:0]       wdata,
    output logic [N_IRQS-1:0] bits,
    output logic [31:0]       rd_word
);
    localparam int WORDS  = N_IRQS / 32;
    localparam int STORED = WORDS - FIRST_WORD;

    logic [STORED*32-1:0] shared_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shared_q <= '0;
        end else begin
            for (int w = FIRST_WORD; w < WORDS; w++) begin
                if (word_idx == 5'(w)) begin
                    if (set_we)
                        shared_q[(w-FIRST_WORD)*32 +: 32] <= shared_q[(w-FIRST_WORD)*32 +: 32] | wdata;
                    else if (clr_we)
                        shared_q[(w-FIRST_WORD)*32 +: 32] <= shared_q[(w-FIRST_WORD)*32 +: 32] & ~wdata;
                end
            end
        end
    end

    assign bits = {shared_q, {(FIRST_WORD*32){1'b0}}};

    always_comb begin
        rd_word = '0;
        for (int w = FIRST_WORD; w < WORDS; w++)
            if (word_idx == 5'(w)) rd_word = shared_q[(w-FIRST_WORD)*32 +: 32];
    end

    generate
        for (genvar w = FIRST_WORD; w < WORDS; w++) begin : g_word_chk
            // R5 R6
            set_bits_chk: assert property (@(posedge clk) disable iff (rst)
                (set_we && word_idx == 5'(w)) |=>
                    ((bits[w*32 +: 32] & $past(wdata)) == $past(wdata)));
            // R5 R6
            clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
                (clr_we && word_idx == 5'(w)) |=>
                    ((bits[w*32 +: 32] & $past(wdata)) == 32'd0));
            // R5 R6
            keep_bits_chk: assert property (@(posedge clk) disable iff (rst)
                ((set_we || clr_we) && word_idx == 5'(w)) |=>
                    ((bits[w*32 +: 32] & ~$past(wdata)) == ($past(bits[w*32 +: 32]) & ~$past(wdata))));
        end
    endgenerate

endmodule

// File: rtl/irqd_word_store.sv
module irqd_word_store #(
    parameter int N_WORDS    = 24,
    parameter int FIRST_WORD = 8,
    parameter int IDX_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rd_word
);
    localparam int STORED = N_WORDS - FIRST_WORD;

    logic [STORED*32-1:0] stor_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stor_q <= '0;
        end else if (we) begin
            for (int w = FIRST_WORD; w < N_WORDS; w++)
                if (idx == IDX_W'(w)) stor_q[(w-FIRST_WORD)*32 +: 32] <= wdata;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int w = FIRST_WORD; w < N_WORDS; w++)
            if (idx == IDX_W'(w)) rd_word = stor_q[(w-FIRST_WORD)*32 +: 32];
    end

    // R8 R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(stor_q));

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs #(
    parameter int NUM_IRQS = 96
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [irqd_pkg::ADDR_W-1:0]   req_addr,
    input  logic [31:0]                   req_wdata,
    output logic                          rsp_valid,
    output logic [31:0]                   rsp_rdata,
    output logic                          grp1_en,
    output logic [NUM_IRQS-1:0]           irq_enable,
    output logic [NUM_IRQS-1:0]           irq_pending
);
    import irqd_pkg::*;

    localparam int PRIV_IRQS  = 32;
    localparam int BMAP_FIRST = PRIV_IRQS / 32;
    localparam int PRIO_WORDS = NUM_IRQS / 4;
    localparam int PRIO_FIRST = PRIV_IRQS / 4;
    localparam int CFG_WORDS  = NUM_IRQS / 16;
    localparam int CFG_FIRST  = PRIV_IRQS / 16;
    localparam logic [31:0] TYPE_WORD = type_word(NUM_IRQS);

    decode_t     dec;
    logic        wr, rd;
    logic        grp1_q;
    logic [31:0] en_rd, pd_rd, prio_rd, cfg_rd;
    logic [31:0] rd_mux;
    ctrl_word_t  ctrl_rd;

    assign wr = req_valid &&  req_write;
    assign rd = req_valid && !req_write;

    irqd_decode u_decode (.addr(req_addr), .dec(dec));

    always_ff @(posedge clk) begin
        if (rst)                              grp1_q <= 1'b0;
        else if (wr && dec.region == RG_CTRL) grp1_q <= req_wdata[1];
    end
    assign grp1_en = grp1_q;

    irqd_setclr_map #(.N_IRQS(NUM_IRQS), .FIRST_WORD(BMAP_FIRST)) u_enable (
        .clk(clk), .rst(rst),
        .set_we(wr && dec.region == RG_SET_EN),
        .clr_we(wr && dec.region == RG_CLR_EN),
        .word_idx(dec.index[4:0]), .wdata(req_wdata),
        .bits(irq_enable), .rd_word(en_rd)
    );

    irqd_setclr_map #(.N_IRQS(NUM_IRQS), .FIRST_WORD(BMAP_FIRST)) u_pending (
        .clk(clk), .rst(rst),
        .set_we(wr && dec.region == RG_SET_PD),
        .clr_we(wr && dec.region == RG_CLR_PD),
        .word_idx(dec.index[4:0]), .wdata(req_wdata),
        .bits(irq_pending), .rd_word(pd_rd)
    );

    irqd_word_store #(.N_WORDS(PRIO_WORDS), .FIRST_WORD(PRIO_FIRST), .IDX_W(8)) u_prio (
        .clk(clk), .rst(rst),
        .we(wr && dec.region == RG_PRIO),
        .idx(dec.index), .wdata(req_wdata), .rd_word(prio_rd)
    );

    irqd_word_store #(.N_WORDS(CFG_WORDS), .FIRST_WORD(CFG_FIRST), .IDX_W(6)) u_cfg (
        .clk(clk), .rst(rst),
        .we(wr && dec.region == RG_CFG),
        .idx(dec.index[5:0]), .wdata(req_wdata), .rd_word(cfg_rd)
    );

    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd.grp1     = grp1_q;
        ctrl_rd.route_on = 1'b1;
        ctrl_rd.sec_off  = 1'b1;
    end

    always_comb begin
        unique case (dec.region)
            RG_CTRL:              rd_mux = ctrl_rd;
            RG_TYPE:              rd_mux = TYPE_WORD;
            RG_GROUP:             rd_mux = '1;
            RG_SET_EN, RG_CLR_EN: rd_mux = en_rd;
            RG_SET_PD, RG_CLR_PD: rd_mux = pd_rd;
            RG_PRIO:              rd_mux = prio_rd;
            RG_CFG:               rd_mux = cfg_rd;
            RG_IDENT2:            rd_mux = IDENT2_VALUE;
            default:              rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd;
            if (rd) rsp_rdata <= rd_mux;
        end
    end

    // R2
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd |=> rsp_valid);
    // R2
    no_rsp_otherwise_chk: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rsp_valid);
    // R3
    ctrl_fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && dec.region == RG_CTRL) |=>
            (rsp_rdata[6] && rsp_rdata[4] && !rsp_rdata[0]));
    // R3
    grp1_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.region == RG_CTRL) |=> (grp1_en == $past(req_wdata[1])));
    // R11
    ident_value_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && req_addr == A_IDENT2) |=> (rsp_rdata == 32'h0000_003B));
    // R12
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.region == RG_ZERO) |=>
            ($stable(irq_enable) && $stable(irq_pending) && $stable(grp1_en)));

endmodule

// File: tb/test_irq_dist_regs.sv
module test_irq_dist_regs;
    localparam int N = 96;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [11:0]   req_addr  = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          grp1_en;
    logic [N-1:0]  irq_enable;
    logic [N-1:0]  irq_pending;

    always #10 clk = ~clk;

    irq_dist_regs #(.NUM_IRQS(N)) i_irq_dist_regs (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .grp1_en(grp1_en), .irq_enable(irq_enable), .irq_pending(irq_pending)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic          m_g1;
    logic [N-1:0]  m_en, m_pd;
    logic [31:0]   m_prio [N/4];
    logic [31:0]   m_cfg  [N/16];

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int w;
        if (a == 12'h000) return 32'h50 | (32'(m_g1) << 1);
        if (a == 12'h001) return 32'd2 | (32'd9 << 19);        // R4: 96/32-1, ID width 10
        if (a >= 12'h020 && a <= 12'h03F) return 32'hFFFF_FFFF;
        if (a >= 12'h040 && a <= 12'h07F) begin
            w = int'(a[4:0]);
            return (w >= 1 && w < N/32) ? m_en[w*32 +: 32] : 32'd0;
        end
        if (a >= 12'h080 && a <= 12'h0BF) begin
            w = int'(a[4:0]);
            return (w >= 1 && w < N/32) ? m_pd[w*32 +: 32] : 32'd0;
        end
        if (a[11:8] == 4'h1) begin
            w = int'(a[7:0]);
            return (w >= 8 && w < N/4) ? m_prio[w] : 32'd0;
        end
        if (a[11:6] == 6'h0C) begin
            w = int'(a[5:0]);
            return (w >= 2 && w < N/16) ? m_cfg[w] : 32'd0;
        end
        if (a == 12'hFFA) return 32'h3B;
        return 32'd0;
    endfunction

    function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
        int w;
        w = int'(a[4:0]);
        if (a == 12'h000) m_g1 = d[1];
        else if (a >= 12'h040 && a <= 12'h05F) begin if (w >= 1 && w < N/32) m_en[w*32 +: 32] = m_en[w*32 +: 32] | d; end
        else if (a >= 12'h060 && a <= 12'h07F) begin if (w >= 1 && w < N/32) m_en[w*32 +: 32] = m_en[w*32 +: 32] & ~d; end
        else if (a >= 12'h080 && a <= 12'h09F) begin if (w >= 1 && w < N/32) m_pd[w*32 +: 32] = m_pd[w*32 +: 32] | d; end
        else if (a >= 12'h0A0 && a <= 12'h0BF) begin if (w >= 1 && w < N/32) m_pd[w*32 +: 32] = m_pd[w*32 +: 32] & ~d; end
        else if (a[11:8] == 4'h1) begin
            if (int'(a[7:0]) >= 8 && int'(a[7:0]) < N/4) m_prio[int'(a[7:0])] = d;
        end
        else if (a[11:6] == 6'h0C) begin
            if (int'(a[5:0]) >= 2 && int'(a[5:0]) < N/16) m_cfg[int'(a[5:0])] = d;
        end
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        if (a == 12'h000) return "R3";
        if (a == 12'h001) return "R4";
        if (a >= 12'h020 && a <= 12'h03F) return "R10";
        if (a >= 12'h040 && a <= 12'h07F) return (a[4:0] >= 1 && a[4:0] < N/32) ? "R5" : "R7";
        if (a >= 12'h080 && a <= 12'h0BF) return (a[4:0] >= 1 && a[4:0] < N/32) ? "R6" : "R7";
        if (a[11:8] == 4'h1) return "R8";
        if (a[11:6] == 6'h0C) return "R9";
        if (a >= 12'hFF4) return "R11";
        return "R12";
    endfunction

    task automatic check(input string tag, input logic [11:0] a,
                         input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr=%h got=%h exp=%h", tag, a, got, exp);
        end
    endtask

    task automatic check_outputs(input string tag, input logic [11:0] a);
        check(tag, a, N'(grp1_en), N'(m_g1));
        check(tag, a, irq_enable, m_en);
        check(tag, a, irq_pending, m_pd);
        check("R7", a, N'(irq_enable[31:0] | irq_pending[31:0]), '0);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        model_write(a, d);
        check("R2", a, N'(rsp_valid), N'(1'b0));
        check_outputs(tag_of(a), a);
    endtask

    task automatic do_read(input logic [11:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", a, N'(rsp_valid), N'(1'b1));
        check(tag_of(a), a, N'(rsp_rdata), N'(exp_read(a)));
    endtask

    function automatic logic [11:0] pick_addr();
        case ($urandom % 8)
            0: return 12'h040 + 12'($urandom % 5);
            1: return 12'h060 + 12'($urandom % 5);
            2: return 12'h080 + 12'($urandom % 5);
            3: return 12'h0A0 + 12'($urandom % 5);
            4: return 12'h100 + 12'($urandom % 28);
            5: return 12'h300 + 12'($urandom % 8);
            6: return 12'($urandom % 4);
            default: return 12'($urandom % 4096);
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_g1 = 0; m_en = '0; m_pd = '0;
        foreach (m_prio[i]) m_prio[i] = '0;
        foreach (m_cfg[i])  m_cfg[i]  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", 12'h0, N'(rsp_valid), '0);
        check("R1", 12'h0, irq_enable | irq_pending, '0);
        check("R1", 12'h0, N'(grp1_en), '0);
        do_read(12'h000);
        do_read(12'h108);
        do_read(12'h302);
        do_read(12'h041);

        // R3 group-0 ignored, group-1 stored, fixed ones
        do_write(12'h000, 32'hFFFF_FFFF);
        do_read(12'h000);
        do_write(12'h000, 32'h0000_0001);
        do_read(12'h000);
        do_write(12'h000, 32'h0000_0002);
        do_read(12'h000);
        // R4 type register ignores writes
        do_write(12'h001, 32'hFFFF_FFFF);
        do_read(12'h001);
        check("R4", 12'h001, N'(rsp_rdata), N'(32'h0048_0002));
        // R5 mixed set/clear
        do_write(12'h041, 32'hA5A5_0F01);
        do_write(12'h042, 32'h8000_0001);
        do_write(12'h061, 32'h0000_0F00);
        do_read(12'h041);
        do_read(12'h062);
        // R7 private and past-end words
        do_write(12'h040, 32'hFFFF_FFFF);
        do_write(12'h080, 32'hFFFF_FFFF);
        do_write(12'h043, 32'hFFFF_FFFF);
        do_read(12'h040);
        do_read(12'h0A0);
        do_read(12'h043);
        // R6 pending set/clear
        do_write(12'h082, 32'h1234_5678);
        do_write(12'h0A2, 32'h0000_0078);
        do_read(12'h082);
        // R8 priority
        do_write(12'h107, 32'hDEAD_BEEF);
        do_write(12'h108, 32'hC0FF_EE01);
        do_write(12'h117, 32'h0102_0304);
        do_write(12'h118, 32'hFFFF_FFFF);
        do_read(12'h107);
        do_read(12'h108);
        do_read(12'h117);
        do_read(12'h118);
        // R9 configuration
        do_write(12'h301, 32'hFFFF_FFFF);
        do_write(12'h302, 32'h5555_AAAA);
        do_write(12'h306, 32'hFFFF_FFFF);
        do_read(12'h301);
        do_read(12'h302);
        do_read(12'h306);
        // R10 group range
        do_write(12'h021, 32'h0);
        do_read(12'h021);
        do_read(12'h03F);
        // R11 identification
        do_read(12'hFFA);
        do_read(12'hFF5);
        do_write(12'hFFA, 32'h0);
        do_read(12'hFFA);
        // R12 unmapped ranges
        do_write(12'h0C1, 32'hFFFF_FFFF);
        do_write(12'h200, 32'hFFFF_FFFF);
        do_write(12'h002, 32'hFFFF_FFFF);
        do_read(12'h0C1);
        do_read(12'h200);
        do_read(12'h002);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            a = pick_addr();
            if ($urandom % 2) do_write(a, $urandom);
            else              do_read(a);
        end
        // final sweep of stored ranges
        for (int i = 0; i < 5; i++) begin
            do_read(12'h040 + 12'(i));
            do_read(12'h080 + 12'(i));
        end
        for (int i = 0; i < 28; i++) do_read(12'h100 + 12'(i));
        for (int i = 0; i < 8; i++)  do_read(12'h300 + 12'(i));
        finish_run();
    end

endmodule